// File: doc/BRIEF.md
# Exact-Match Level Trigger with Serial Level Load

This block watches a stream of converter samples and raises a trigger when a valid sample is bit-for-bit identical to a stored level word. A host loads the level through a three-wire serial port: a data line, a shift clock and a load strobe. The bits go into a shadow register, high byte first. The working level word changes only when the host pulses the load strobe after a full word has been shifted. This lets the host stage a new level without disturbing the comparison that is running.

Each matching valid sample produces a one-cycle trigger pulse. When the trigger source select chooses the input signal, the same match also sets a run flag that starts an acquisition burst. The run flag stays set through later matches and clears only on the stop input or on reset. A separate reading counter, outside this block, decides how long the burst lasts and drives stop.

Top module: `level_match_trigger`

## Requirements
- R1: Synchronous reset (`rst` high) clears `trig_out` and `run_out` to 0, clears the stored level to all zeros and clears the count of shifted bits.
- R2: A shift happens in the system clock cycle in which `ser_clk` is sampled high after being sampled low. The value on `ser_data` in that cycle enters the least significant end of the shadow register. Bits therefore arrive most significant bit first, so the first byte sent becomes bits 15:8.
- R3: A load strobe taken when at least 16 bits have been shifted since the last accepted load (or since reset) copies the shadow register into the working level. Only the 16 most recent bits are kept.
- R4: A load strobe given after fewer than 16 shifts has no effect on the working level.
- R5: `trig_out` is high in the cycle after each clock in which `smp_valid` is high and `smp_data` equals the level. It is high for exactly one cycle per such sample, so back-to-back matches give back-to-back pulses.
- R6: A sample that differs in any bit, or that is presented with `smp_valid` low, produces no trigger.
- R7: With `src_signal` = 1 (input-signal source), a match sets `run_out` on the same clock edge that raises `trig_out`.
- R8: With `src_signal` = 0, matches still pulse `trig_out` but do not set `run_out`.
- R9: Once set, `run_out` stays high through further matches and non-matches. It clears only on `stop` or reset. When `stop` and a match arrive in the same cycle, `stop` wins.
- R10: A sample presented in the same cycle as an accepted load is compared against the previous level. The new level applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_data | input | 1 | Serial level data bit |
| ser_clk | input | 1 | Serial shift clock; each rising level change shifts one bit (sampled on clk) |
| ser_load | input | 1 | Strobe that transfers the shadow register to the working level |
| smp_data | input | 16 | Converter sample |
| smp_valid | input | 1 | Marks `smp_data` as a sample for this cycle |
| src_signal | input | 1 | 1 = input-signal trigger source, 0 = other source |
| stop | input | 1 | Clears the run flag |
| trig_out | output | 1 | One-cycle trigger pulse per matching sample |
| run_out | output | 1 | Run/stop flag |

## Verification
The hardest conditions to reach from the ports involve the serial port's bit count, not the comparator. These are a load strobe after a partial word, a stream longer than one word, and a load that lands in the same cycle as a sample still meant for the old level. The stimulus shifts a half word and strobes load to show that the old level survives. It then completes the word and checks that the combined bytes became the level. It also shifts 20 bits to show that only the last 16 count. The collision between stop and a match is set up by first latching the run flag, then driving `stop` and a matching sample on the same edge.

// File: rtl/lmt_pkg.sv
package lmt_pkg;

  localparam int unsigned DEF_LEVEL_W = 16;
  localparam int unsigned DEF_SLICE_W = 8;

  typedef enum logic {
    SRC_OTHER = 1'b0,
    SRC_INPUT = 1'b1
  } trig_src_e;

endpackage

// File: rtl/lmt_serial_latch.sv
module lmt_serial_latch #(
  parameter int unsigned W = lmt_pkg::DEF_LEVEL_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ser_data,
  input  logic         ser_clk,
  input  logic         ser_load,
  output logic [W-1:0] level,
  output logic         shift_evt,
  output logic         load_evt
);
  localparam int unsigned CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(W);

  logic             ser_clk_d;
  logic [W-1:0]     shadow_q;
  logic [W-1:0]     level_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full;

  function automatic logic [W-1:0] push_bit(input logic [W-1:0] s, input logic b);
    return {s[W-2:0], b};
  endfunction

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c);
    return (c == FULL_CNT) ? c : c + 1'b1;
  endfunction

  assign shift_evt = ser_clk & ~ser_clk_d;
  assign full      = (cnt_q == FULL_CNT);
  assign load_evt  = ser_load & full;
  assign level     = level_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_clk_d <= 1'b0;
      shadow_q  <= '0;
      level_q   <= '0;
      cnt_q     <= '0;
    end else begin
      ser_clk_d <= ser_clk;
      if (shift_evt) shadow_q <= push_bit(shadow_q, ser_data);
      if (load_evt) begin
        level_q <= shadow_q;
        cnt_q   <= shift_evt ? CNT_W'(1) : '0;
      end else if (shift_evt) begin
        cnt_q <= bump(cnt_q);
      end
    end
  end

  assert_shift_lsb_entry_R2: assert property (@(posedge clk) disable iff (rst)
    shift_evt |=> shadow_q[0] == $past(ser_data));

  assert_level_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !load_evt |=> $stable(level_q));

  assert_level_change_needs_load_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && level_q != $past(level_q)) |-> ($past(ser_load) && $past(cnt_q) == FULL_CNT));

endmodule

// File: rtl/lmt_compare.sv
module lmt_compare #(
  parameter int unsigned W       = lmt_pkg::DEF_LEVEL_W,
  parameter int unsigned SLICE_W = lmt_pkg::DEF_SLICE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] level,
  input  logic [W-1:0] smp_data,
  input  logic         smp_valid,
  output logic         hit,
  output logic         trig
);
  localparam int unsigned NSLICE = W / SLICE_W;

  logic [NSLICE-1:0] slice_eq;
  logic              trig_q;

  function automatic logic slice_match(input logic [SLICE_W-1:0] a, input logic [SLICE_W-1:0] b);
    return (a ^ b) == '0;
  endfunction

  for (genvar g = 0; g < NSLICE; g++) begin : g_slice
    assign slice_eq[g] = slice_match(level[g*SLICE_W +: SLICE_W], smp_data[g*SLICE_W +: SLICE_W]);
  end

  assign hit  = smp_valid & (&slice_eq);
  assign trig = trig_q;

  always_ff @(posedge clk) begin
    if (rst) trig_q <= 1'b0;
    else     trig_q <= hit;
  end

  assert_no_trig_on_mismatch_R6: assert property (@(posedge clk) disable iff (rst)
    (!smp_valid || smp_data != level) |=> !trig_q);

endmodule

// File: rtl/lmt_run_ctl.sv
module lmt_run_ctl (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic src_sel,
  input  logic stop,
  output logic run
);
  import lmt_pkg::*;

  trig_src_e src;
  logic      run_q;
  logic      arm;

  assign src = trig_src_e'(src_sel);
  assign arm = hit && (src == SRC_INPUT);
  assign run = run_q;

  always_ff @(posedge clk) begin
    if (rst)       run_q <= 1'b0;
    else if (stop) run_q <= 1'b0;
    else if (arm)  run_q <= 1'b1;
  end

  assert_run_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (run_q && !stop) |=> run_q);

  assert_stop_clears_R9: assert property (@(posedge clk) disable iff (rst)
    stop |=> !run_q);

  assert_run_needs_input_src_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(run_q) |-> ($past(src_sel) && $past(hit)));

endmodule

// File: rtl/level_match_trigger.sv
module level_match_trigger #(
  parameter int unsigned LEVEL_W = lmt_pkg::DEF_LEVEL_W,
  parameter int unsigned SLICE_W = lmt_pkg::DEF_SLICE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ser_data,
  input  logic               ser_clk,
  input  logic               ser_load,
  input  logic [LEVEL_W-1:0] smp_data,
  input  logic               smp_valid,
  input  logic               src_signal,
  input  logic               stop,
  output logic               trig_out,
  output logic               run_out
);
  logic [LEVEL_W-1:0] level;
  logic               shift_evt;
  logic               load_evt;
  logic               hit;

  lmt_serial_latch #(.W(LEVEL_W)) u_latch (
    .clk(clk), .rst(rst), .ser_data(ser_data), .ser_clk(ser_clk),
    .ser_load(ser_load), .level(level), .shift_evt(shift_evt), .load_evt(load_evt)
  );

  lmt_compare #(.W(LEVEL_W), .SLICE_W(SLICE_W)) u_cmp (
    .clk(clk), .rst(rst), .level(level), .smp_data(smp_data),
    .smp_valid(smp_valid), .hit(hit), .trig(trig_out)
  );

  lmt_run_ctl u_run (
    .clk(clk), .rst(rst), .hit(hit), .src_sel(src_signal),
    .stop(stop), .run(run_out)
  );

  assert_trig_needs_valid_R5: assert property (@(posedge clk) disable iff (rst)
    trig_out |-> $past(smp_valid));

  assert_run_rises_with_trig_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(run_out) |-> trig_out);

  assert_load_uses_old_level_R10: assert property (@(posedge clk) disable iff (rst)
    (load_evt && smp_valid && smp_data == level) |=> trig_out);

endmodule

// File: tb/level_match_trigger_tb.sv
module level_match_trigger_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser_data = 1'b0;
  logic        ser_clk = 1'b0;
  logic        ser_load = 1'b0;
  logic [15:0] smp_data = '0;
  logic        smp_valid = 1'b0;
  logic        src_signal = 1'b0;
  logic        stop = 1'b0;
  logic        trig_out;
  logic        run_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  level_match_trigger u_dut (
    .clk(clk), .rst(rst), .ser_data(ser_data), .ser_clk(ser_clk), .ser_load(ser_load),
    .smp_data(smp_data), .smp_valid(smp_valid), .src_signal(src_signal), .stop(stop),
    .trig_out(trig_out), .run_out(run_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic shift_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = v[i];
      ser_clk  = 1'b1;
      @(negedge clk);
      ser_clk  = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic strobe_load();
    ser_load = 1'b1;
    @(negedge clk);
    ser_load = 1'b0;
    @(negedge clk);
  endtask

  // One sample, then check trigger/run after one edge and pulse end after the next.
  task automatic probe(input logic [15:0] d, input logic v, input logic exp_trig,
                       input logic exp_run, input string req);
    smp_data  = d;
    smp_valid = v;
    @(negedge clk);
    chk({req, " trig"}, trig_out, exp_trig);
    chk({req, " run"}, run_out, exp_run);
    smp_valid = 1'b0;
    @(negedge clk);
    chk({req, " pulse end R5"}, trig_out, 1'b0);
  endtask

  task automatic t_reset();
    chk("R1 trig after reset", trig_out, 1'b0);
    chk("R1 run after reset", run_out, 1'b0);
    probe(16'h0000, 1'b1, 1'b1, 1'b0, "R1 zero level");
  endtask

  task automatic t_match_patterns();
    src_signal = 1'b0;
    shift_bits(32'hA53C, 16);
    strobe_load();
    probe(16'hA53C, 1'b1, 1'b1, 1'b0, "R5 R8 match");
    probe(16'hA53D, 1'b1, 1'b0, 1'b0, "R6 lsb differs");
    probe(16'h253C, 1'b1, 1'b0, 1'b0, "R6 msb differs");
    probe(16'h3CA5, 1'b1, 1'b0, 1'b0, "R2 byte order");
    probe(16'hA53C, 1'b0, 1'b0, 1'b0, "R6 invalid");
  endtask

  task automatic t_back_to_back();
    smp_data  = 16'hA53C;
    smp_valid = 1'b1;
    @(negedge clk);
    chk("R5 first of pair", trig_out, 1'b1);
    @(negedge clk);
    chk("R5 second of pair", trig_out, 1'b1);
    smp_valid = 1'b0;
    @(negedge clk);
    chk("R5 pair end", trig_out, 1'b0);
  endtask

  task automatic t_partial_load();
    shift_bits(32'hFF, 8);
    strobe_load();
    probe(16'hA53C, 1'b1, 1'b1, 1'b0, "R4 partial load ignored");
    shift_bits(32'h00, 8);
    strobe_load();
    probe(16'hFF00, 1'b1, 1'b1, 1'b0, "R3 two bytes combined");
    probe(16'hA53C, 1'b1, 1'b0, 1'b0, "R3 old level gone");
    shift_bits(32'hF, 4);
    shift_bits(32'h1234, 16);
    strobe_load();
    probe(16'h1234, 1'b1, 1'b1, 1'b0, "R3 last 16 bits");
  endtask

  task automatic t_load_collision();
    shift_bits(32'hBEEF, 16);
    ser_load  = 1'b1;
    smp_data  = 16'h1234;
    smp_valid = 1'b1;
    @(negedge clk);
    chk("R10 old level in load cycle", trig_out, 1'b1);
    ser_load  = 1'b0;
    smp_valid = 1'b0;
    @(negedge clk);
    probe(16'hBEEF, 1'b1, 1'b1, 1'b0, "R10 new level next");
    probe(16'h1234, 1'b1, 1'b0, 1'b0, "R10 old level retired");
  endtask

  task automatic t_run();
    src_signal = 1'b1;
    probe(16'h1111, 1'b1, 1'b0, 1'b0, "R6 no run on mismatch");
    probe(16'hBEEF, 1'b1, 1'b1, 1'b1, "R7 run set with trig");
    probe(16'hBEEF, 1'b1, 1'b1, 1'b1, "R9 rematch keeps run");
    src_signal = 1'b0;
    probe(16'h0001, 1'b1, 1'b0, 1'b1, "R9 run held");
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R9 stop clears run", run_out, 1'b0);
    probe(16'hBEEF, 1'b1, 1'b1, 1'b0, "R8 other source no run");
    src_signal = 1'b1;
    probe(16'hBEEF, 1'b1, 1'b1, 1'b1, "R7 rearm");
    stop      = 1'b1;
    smp_data  = 16'hBEEF;
    smp_valid = 1'b1;
    @(negedge clk);
    chk("R9 stop wins trig", trig_out, 1'b1);
    chk("R9 stop wins run", run_out, 1'b0);
    stop      = 1'b0;
    smp_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset_midrun();
    probe(16'hBEEF, 1'b1, 1'b1, 1'b1, "R7 set before reset");
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 run cleared", run_out, 1'b0);
    chk("R1 trig cleared", trig_out, 1'b0);
    probe(16'h0000, 1'b1, 1'b1, 1'b1, "R1 level back to zero");
    probe(16'hBEEF, 1'b1, 1'b0, 1'b1, "R1 old level cleared");
    src_signal = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_match_patterns();
    t_back_to_back();
    t_partial_load();
    t_load_collision();
    t_run();
    t_reset_midrun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule